// File: doc/BRIEF.md
# Memory Error First/Next Logger

This block sits beside the error-detection logic of a two-channel memory controller and turns a stream of error events into a small set of software-visible registers. Each event carries a 5-bit error type, the channel number, and the location of the failing access: bank, rank, buffer ID, CAS and RAS. It also carries the ECC syndrome and the ECC locator. The first event that finds no error held lands in a first-error flag register. Every later event accumulates in a next-error flag register with the same layout. Each flag register records which channel raised the error.

Each channel also keeps three detail logs: non-recoverable, recoverable and recoverable-data. A per-channel valid-marker register gates these logs. The numeric error type decides which log an event fills. A log that is marked valid is frozen until software clears its marker. Software reads registers through a plain address/data port and writes the value it read back to the same address. Flags and markers are write-one-to-clear, so this write-back retires exactly the events it saw. A summary output is high whenever the first-error register holds a memory error.

Top module: `mem_err_logger`

## Requirements
- R1: An event's type selects one flag bit: type 1 sets bit 0, and types 4, 5, 6, 10, 11, 12, 14, 15, 16 and 18 set the bit of the same number. Any other type sets no flag, fills no log and changes no register.
- R2: When no type bit is set in the first-error register (address 0), an event sets its bit there. The event's channel number is written into bits 28 and up of that register.
- R3: While any type bit of the first-error register is set, events change only the next-error register (address 1). There they set their bit and overwrite bits 28 and up with their channel. The first-error register keeps its value.
- R4: Output `err_any` is high exactly when the first-error register holds at least one type bit other than bit 18. Bit 18 is the serial presence-detect protocol error.
- R5: Writing to a flag register or a valid-marker register clears each bit written as 1. Writes to log registers have no effect.
- R6: A type 14, 15 or 16 event fills its channel's recoverable log (valid marker bit 1) and its channel's recoverable-data log (valid marker bit 2, holding the 32-bit syndrome and the 18-bit locator). Log word A places the type at bits 19:15, the bank at 14:12, the rank at 10:8 and the buffer ID at 7:0. Log word B places CAS at bits 28:16 and RAS at 15:0.
- R7: A type 1, 4, 5, 6, 10, 11 or 12 event fills its channel's non-recoverable log (words A and B, same layout as R6) and sets valid marker bit 0. Type 18 fills no log.
- R8: A log whose valid marker is set keeps its contents when later events of its class arrive. Once the marker is cleared, the next such event fills it again.
- R9: When an event and a clearing write touch the same flag bit or valid marker in the same cycle, the event wins. The bit ends set, and the log is refilled with the new event.
- R10: Address map: 0 is the first-error register and 1 is the next-error register. Channel c occupies 8+8c: the valid marker at +0, non-recoverable words A and B at +1 and +2, recoverable words A and B at +3 and +4, the syndrome at +5 and the locator at +6. Every other address reads as 0.
- R11: Reset clears every register and drives `err_any` low. The internal reset is released two clock edges after `rst_n` rises.
- R12: An event on one channel leaves the valid markers and logs of every other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | Error event present this cycle |
| evt_type | input | 5 | Numeric error type |
| evt_chan | input | CHW (1) | Channel that raised the event |
| evt_bank | input | 3 | Bank of failing access |
| evt_rank | input | 3 | Rank of failing access |
| evt_bufid | input | 8 | Buffer ID of failing access |
| evt_cas | input | 13 | Column address |
| evt_ras | input | 16 | Row address |
| evt_synd | input | 32 | ECC syndrome |
| evt_eccloc | input | 18 | ECC locator |
| sw_wr | input | 1 | Register write strobe |
| sw_addr | input | AW (5) | Register address |
| sw_wdata | input | 32 | Write data, ones clear |
| sw_rdata | output | 32 | Read data for `sw_addr` |
| err_any | output | 1 | First-error register holds a memory error |

## Verification
The assertions take the event and write inputs to be fully known on every clock edge once reset has been released. A rise of a flag, valid marker or summary bit is only ever traced back to `evt_valid` in the preceding cycle. The assertions also take a clearing write to be the only thing that may change a frozen register. The bench changes all inputs on the falling edge, so that they are settled at each rising edge. It raises `evt_valid` and `sw_wr` for exactly one cycle per operation. The only time the bench issues an event and a write in the same cycle is the deliberate coincidence case.

// File: rtl/mel_pkg.sv
package mel_pkg;

  localparam int DW       = 32;
  localparam int TYPE_W   = 5;
  localparam int BANK_W   = 3;
  localparam int RANK_W   = 3;
  localparam int BUF_W    = 8;
  localparam int CAS_W    = 13;
  localparam int RAS_W    = 16;
  localparam int SYN_W    = 32;
  localparam int LOC_W    = 18;

  // log word layout
  localparam int A_TYPE_LSB = 15;
  localparam int A_BANK_LSB = 12;
  localparam int A_RANK_LSB = 8;
  localparam int B_CAS_LSB  = 16;

  // flag register layout
  localparam int CHAN_LSB = 28;
  localparam int SPD_BIT  = 18;
  localparam logic [DW-1:0] ANY_MASK  = 32'h0001_DC71;
  localparam logic [DW-1:0] IMPL_MASK = ANY_MASK | (32'h1 << SPD_BIT);

  // valid marker bits
  localparam int V_NREC = 0;
  localparam int V_REC  = 1;
  localparam int V_RDAT = 2;
  localparam int V_W    = 3;

  // per-channel register offsets
  localparam logic [2:0] OFS_VLD   = 3'd0;
  localparam logic [2:0] OFS_NRECA = 3'd1;
  localparam logic [2:0] OFS_NRECB = 3'd2;
  localparam logic [2:0] OFS_RECA  = 3'd3;
  localparam logic [2:0] OFS_RECB  = 3'd4;
  localparam logic [2:0] OFS_SYN   = 3'd5;
  localparam logic [2:0] OFS_LOC   = 3'd6;

  typedef struct packed {
    logic [TYPE_W-1:0] etype;
    logic [BANK_W-1:0] bank;
    logic [RANK_W-1:0] rank;
    logic [BUF_W-1:0]  bufid;
    logic [CAS_W-1:0]  cas;
    logic [RAS_W-1:0]  ras;
    logic [SYN_W-1:0]  synd;
    logic [LOC_W-1:0]  loc;
  } evt_t;

  function automatic logic [DW-1:0] type_flag(input logic [TYPE_W-1:0] t);
    logic [DW-1:0] f;
    f = '0;
    case (t)
      5'd1:                       f[0] = 1'b1;
      5'd4, 5'd5, 5'd6,
      5'd10, 5'd11, 5'd12,
      5'd14, 5'd15, 5'd16, 5'd18: f[t] = 1'b1;
      default:                    f = '0;
    endcase
    return f;
  endfunction

  function automatic logic is_corr(input logic [TYPE_W-1:0] t);
    return (t == 5'd14) || (t == 5'd15) || (t == 5'd16);
  endfunction

  function automatic logic is_uncorr(input logic [TYPE_W-1:0] t);
    return (t == 5'd1) || (t == 5'd4) || (t == 5'd5) || (t == 5'd6) ||
           (t == 5'd10) || (t == 5'd11) || (t == 5'd12);
  endfunction

  function automatic logic [DW-1:0] word_a(input evt_t e);
    logic [DW-1:0] w;
    w = '0;
    w[A_TYPE_LSB +: TYPE_W] = e.etype;
    w[A_BANK_LSB +: BANK_W] = e.bank;
    w[A_RANK_LSB +: RANK_W] = e.rank;
    w[0 +: BUF_W]           = e.bufid;
    return w;
  endfunction

  function automatic logic [DW-1:0] word_b(input evt_t e);
    logic [DW-1:0] w;
    w = '0;
    w[B_CAS_LSB +: CAS_W] = e.cas;
    w[0 +: RAS_W]         = e.ras;
    return w;
  endfunction

endpackage

// File: rtl/mel_rst_sync.sv
module mel_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/mel_flags.sv
module mel_flags
  import mel_pkg::*;
#(
  parameter int CHW = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  input  logic [TYPE_W-1:0] evt_type,
  input  logic [CHW-1:0]    evt_chan,
  input  logic [DW-1:0]     clr_first,
  input  logic [DW-1:0]     clr_next,
  output logic [DW-1:0]     first_q,
  output logic [DW-1:0]     next_q
);
  logic [DW-1:0] flag;
  logic          hit, held;
  logic [DW-1:0] first_d, next_d;
  logic          en_first, en_next;

  always_comb begin
    flag     = type_flag(evt_type);
    hit      = evt_valid && (flag != '0);
    held     = |(first_q & IMPL_MASK);
    first_d  = first_q & ~clr_first;
    next_d   = next_q & ~clr_next;
    en_first = |clr_first;
    en_next  = |clr_next;
    if (hit) begin
      if (held) begin
        next_d                   = next_d | flag;
        next_d[CHAN_LSB +: CHW]  = evt_chan;
        en_next                  = 1'b1;
      end else begin
        first_d                  = first_d | flag;
        first_d[CHAN_LSB +: CHW] = evt_chan;
        en_first                 = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= '0;
      next_q  <= '0;
    end else begin
      if (en_first) first_q <= first_d;
      if (en_next)  next_q  <= next_d;
    end
  end
endmodule

// File: rtl/mel_chan_log.sv
module mel_chan_log
  import mel_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hit,
  input  evt_t           evt,
  input  logic [V_W-1:0] clr_vld,
  output logic [V_W-1:0] vld_q,
  output logic [DW-1:0]  nreca_q,
  output logic [DW-1:0]  nrecb_q,
  output logic [DW-1:0]  reca_q,
  output logic [DW-1:0]  recb_q,
  output logic [DW-1:0]  syn_q,
  output logic [DW-1:0]  loc_q
);
  logic [V_W-1:0] vld_d;
  logic           ld_nrec, ld_rec, ld_rdat, en_vld;

  always_comb begin
    vld_d   = vld_q & ~clr_vld;
    ld_nrec = hit && is_uncorr(evt.etype) && !vld_d[V_NREC];
    ld_rec  = hit && is_corr(evt.etype)   && !vld_d[V_REC];
    ld_rdat = hit && is_corr(evt.etype)   && !vld_d[V_RDAT];
    if (ld_nrec) vld_d[V_NREC] = 1'b1;
    if (ld_rec)  vld_d[V_REC]  = 1'b1;
    if (ld_rdat) vld_d[V_RDAT] = 1'b1;
    en_vld  = (|clr_vld) || ld_nrec || ld_rec || ld_rdat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= '0;
      nreca_q <= '0;
      nrecb_q <= '0;
      reca_q  <= '0;
      recb_q  <= '0;
      syn_q   <= '0;
      loc_q   <= '0;
    end else begin
      if (en_vld) vld_q <= vld_d;
      if (ld_nrec) begin
        nreca_q <= word_a(evt);
        nrecb_q <= word_b(evt);
      end
      if (ld_rec) begin
        reca_q <= word_a(evt);
        recb_q <= word_b(evt);
      end
      if (ld_rdat) begin
        syn_q <= DW'(evt.synd);
        loc_q <= DW'(evt.loc);
      end
    end
  end
endmodule

// File: rtl/mem_err_logger.sv
module mem_err_logger
  import mel_pkg::*;
#(
  parameter  int NCH = 2,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int AW  = $clog2(8 * (NCH + 1))
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  input  logic [TYPE_W-1:0] evt_type,
  input  logic [CHW-1:0]    evt_chan,
  input  logic [BANK_W-1:0] evt_bank,
  input  logic [RANK_W-1:0] evt_rank,
  input  logic [BUF_W-1:0]  evt_bufid,
  input  logic [CAS_W-1:0]  evt_cas,
  input  logic [RAS_W-1:0]  evt_ras,
  input  logic [SYN_W-1:0]  evt_synd,
  input  logic [LOC_W-1:0]  evt_eccloc,
  input  logic              sw_wr,
  input  logic [AW-1:0]     sw_addr,
  input  logic [DW-1:0]     sw_wdata,
  output logic [DW-1:0]     sw_rdata,
  output logic              err_any
);
  localparam logic [DW-1:0] FLAG_W1C = IMPL_MASK | (DW'((1 << CHW) - 1) << CHAN_LSB);
  localparam int BW = AW - 3;

  logic                      srst_n;
  evt_t                      evt;
  logic [DW-1:0]             clr_first, clr_next;
  logic [DW-1:0]             first_q, next_q;
  logic [NCH-1:0][V_W-1:0]   vld_all;
  logic [NCH-1:0][DW-1:0]    nreca_all, nrecb_all, reca_all, recb_all, syn_all, loc_all;
  logic [BW-1:0]             blk;
  logic [2:0]                ofs;

  mel_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .srst_n(srst_n));

  always_comb begin
    evt.etype = evt_type;
    evt.bank  = evt_bank;
    evt.rank  = evt_rank;
    evt.bufid = evt_bufid;
    evt.cas   = evt_cas;
    evt.ras   = evt_ras;
    evt.synd  = evt_synd;
    evt.loc   = evt_eccloc;
  end

  assign clr_first = (sw_wr && sw_addr == AW'(0)) ? (sw_wdata & FLAG_W1C) : '0;
  assign clr_next  = (sw_wr && sw_addr == AW'(1)) ? (sw_wdata & FLAG_W1C) : '0;

  mel_flags #(.CHW(CHW)) u_flags (
    .clk       (clk),
    .rst_n     (srst_n),
    .evt_valid (evt_valid),
    .evt_type  (evt_type),
    .evt_chan  (evt_chan),
    .clr_first (clr_first),
    .clr_next  (clr_next),
    .first_q   (first_q),
    .next_q    (next_q)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic           ch_hit;
    logic [V_W-1:0] ch_clr;

    assign ch_hit = evt_valid && (evt_chan == CHW'(c));
    assign ch_clr = (sw_wr && sw_addr == AW'(8 * (c + 1))) ? sw_wdata[V_W-1:0] : '0;

    mel_chan_log u_log (
      .clk     (clk),
      .rst_n   (srst_n),
      .hit     (ch_hit),
      .evt     (evt),
      .clr_vld (ch_clr),
      .vld_q   (vld_all[c]),
      .nreca_q (nreca_all[c]),
      .nrecb_q (nrecb_all[c]),
      .reca_q  (reca_all[c]),
      .recb_q  (recb_all[c]),
      .syn_q   (syn_all[c]),
      .loc_q   (loc_all[c])
    );
  end

  assign blk = sw_addr[AW-1:3];
  assign ofs = sw_addr[2:0];

  always_comb begin
    sw_rdata = '0;
    if (blk == BW'(0)) begin
      if (ofs == 3'd0) sw_rdata = first_q;
      if (ofs == 3'd1) sw_rdata = next_q;
    end
    for (int c = 0; c < NCH; c++) begin
      if (blk == BW'(c + 1)) begin
        case (ofs)
          OFS_VLD:   sw_rdata = DW'(vld_all[c]);
          OFS_NRECA: sw_rdata = nreca_all[c];
          OFS_NRECB: sw_rdata = nrecb_all[c];
          OFS_RECA:  sw_rdata = reca_all[c];
          OFS_RECB:  sw_rdata = recb_all[c];
          OFS_SYN:   sw_rdata = syn_all[c];
          OFS_LOC:   sw_rdata = loc_all[c];
          default:   sw_rdata = '0;
        endcase
      end
    end
  end

  assign err_any = |(first_q & ANY_MASK);

endmodule

// File: rtl/mel_checker.sv
module mel_checker
  import mel_pkg::*;
#(
  parameter int NCH = 2,
  parameter int AW  = 5
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    evt_valid,
  input logic                    sw_wr,
  input logic [AW-1:0]           sw_addr,
  input logic                    err_any,
  input logic [DW-1:0]           first_q,
  input logic [DW-1:0]           next_q,
  input logic [NCH-1:0][V_W-1:0] vld_all,
  input logic [NCH-1:0][DW-1:0]  nreca_all,
  input logic [NCH-1:0][DW-1:0]  reca_all
);

  // R3: an unwritten first-error register holding an error keeps its value
  p_first_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (((first_q & IMPL_MASK) != '0) && !(sw_wr && sw_addr == AW'(0)))
      |=> (first_q == $past(first_q)));

  // R3: a new next-error bit needs a held first error one cycle earlier
  p_next_needs_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((next_q & IMPL_MASK & ~$past(next_q)) != '0)
      |-> (($past(first_q) & IMPL_MASK) != '0));

  // R4: the summary only rises after an event
  p_any_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_any) |-> $past(evt_valid));

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    // R6: a valid marker only rises after an event
    p_valid_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((vld_all[c] & ~$past(vld_all[c])) != '0) |-> $past(evt_valid));

    // R8: a valid recoverable log is frozen unless its marker is written
    p_rec_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_all[c][V_REC] && !(sw_wr && sw_addr == AW'(8 * (c + 1))))
        |=> $stable(reca_all[c]));

    // R8: a valid non-recoverable log is frozen unless its marker is written
    p_nrec_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_all[c][V_NREC] && !(sw_wr && sw_addr == AW'(8 * (c + 1))))
        |=> $stable(nreca_all[c]));
  end

endmodule

bind mem_err_logger mel_checker #(.NCH(NCH), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .evt_valid (evt_valid),
  .sw_wr     (sw_wr),
  .sw_addr   (sw_addr),
  .err_any   (err_any),
  .first_q   (first_q),
  .next_q    (next_q),
  .vld_all   (vld_all),
  .nreca_all (nreca_all),
  .reca_all  (reca_all)
);

// File: tb/mem_err_logger_test.sv
`timescale 1ns/1ps
module mem_err_logger_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        evt_valid;
  logic [4:0]  evt_type;
  logic [0:0]  evt_chan;
  logic [2:0]  evt_bank;
  logic [2:0]  evt_rank;
  logic [7:0]  evt_bufid;
  logic [12:0] evt_cas;
  logic [15:0] evt_ras;
  logic [31:0] evt_synd;
  logic [17:0] evt_eccloc;
  logic        sw_wr;
  logic [4:0]  sw_addr;
  logic [31:0] sw_wdata;
  logic [31:0] sw_rdata;
  logic        err_any;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  mem_err_logger uut (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_type(evt_type),
    .evt_chan(evt_chan), .evt_bank(evt_bank), .evt_rank(evt_rank),
    .evt_bufid(evt_bufid), .evt_cas(evt_cas), .evt_ras(evt_ras),
    .evt_synd(evt_synd), .evt_eccloc(evt_eccloc), .sw_wr(sw_wr),
    .sw_addr(sw_addr), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
    .err_any(err_any)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk);
    sw_addr = a;
    #1;
    v = sw_rdata;
  endtask

  task automatic chk_reg(input string req, input logic [4:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic load_evt(input logic [4:0] t, input logic c, input logic [2:0] bk,
                          input logic [2:0] rk, input logic [7:0] bid,
                          input logic [12:0] cas, input logic [15:0] ras,
                          input logic [31:0] syn, input logic [17:0] loc);
    evt_type = t; evt_chan = c; evt_bank = bk; evt_rank = rk; evt_bufid = bid;
    evt_cas = cas; evt_ras = ras; evt_synd = syn; evt_eccloc = loc;
  endtask

  // one cycle of event and/or write, driven on the falling edge
  task automatic cycle(input logic e, input logic w, input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    evt_valid = e;
    sw_wr     = w;
    sw_addr   = a;
    sw_wdata  = d;
    @(negedge clk);
    evt_valid = 1'b0;
    sw_wr     = 1'b0;
  endtask

  task automatic simple(input logic [4:0] t, input logic c);
    load_evt(t, c, 3'd0, 3'd0, 8'h00, 13'h0, 16'h0, 32'h0, 18'h0);
    cycle(1'b1, 1'b0, 5'd0, 32'h0);
  endtask

  task automatic t_reset;
    chk_reg("R11 first after reset", 5'd0, 32'h0);
    chk_reg("R11 next after reset", 5'd1, 32'h0);
    chk_reg("R11 ch0 valid after reset", 5'd8, 32'h0);
    chk_reg("R11 ch1 valid after reset", 5'd16, 32'h0);
    chk("R11 err_any after reset", {31'h0, err_any}, 32'h0);
    chk_reg("R10 unmapped addr 2", 5'd2, 32'h0);
    chk_reg("R10 unmapped addr 15", 5'd15, 32'h0);
  endtask

  task automatic t_first_capture;
    load_evt(5'd14, 1'b0, 3'd5, 3'd3, 8'hA5, 13'h1ABC, 16'hBEEF, 32'hDEADBEEF, 18'h21234);
    cycle(1'b1, 1'b0, 5'd0, 32'h0);
    chk_reg("R2 first holds type 14 ch0", 5'd0, 32'h0000_4000);
    chk("R4 err_any on correctable", {31'h0, err_any}, 32'h1);
    chk_reg("R6 ch0 valid rec+data", 5'd8, 32'h6);
    chk_reg("R6 ch0 rec word A", 5'd11, 32'h0007_53A5);
    chk_reg("R6 ch0 rec word B", 5'd12, 32'h1ABC_BEEF);
    chk_reg("R6 ch0 syndrome", 5'd13, 32'hDEAD_BEEF);
    chk_reg("R6 ch0 locator", 5'd14, 32'h0002_1234);
    chk_reg("R12 ch1 valid untouched", 5'd16, 32'h0);
  endtask

  task automatic t_next;
    load_evt(5'd10, 1'b1, 3'd2, 3'd1, 8'h3C, 13'h0123, 16'h4567, 32'h1111_2222, 18'h0);
    cycle(1'b1, 1'b0, 5'd0, 32'h0);
    chk_reg("R3 first unchanged", 5'd0, 32'h0000_4000);
    chk_reg("R3 next type 10 ch1", 5'd1, 32'h1000_0400);
    chk_reg("R7 ch1 valid nrec", 5'd16, 32'h1);
    chk_reg("R7 ch1 nrec word A", 5'd17, 32'h0005_213C);
    chk_reg("R7 ch1 nrec word B", 5'd18, 32'h0123_4567);
    chk_reg("R12 ch0 valid unchanged", 5'd8, 32'h6);
  endtask

  task automatic t_lock;
    load_evt(5'd15, 1'b0, 3'd1, 3'd1, 8'h11, 13'h0001, 16'h0002, 32'h3333_4444, 18'h00005);
    cycle(1'b1, 1'b0, 5'd0, 32'h0);
    chk_reg("R8 ch0 rec word A locked", 5'd11, 32'h0007_53A5);
    chk_reg("R8 ch0 syndrome locked", 5'd13, 32'hDEAD_BEEF);
    chk_reg("R3 next accumulates, chan latest", 5'd1, 32'h0000_8400);
    chk_reg("R3 first still unchanged", 5'd0, 32'h0000_4000);
  endtask

  task automatic t_clear;
    logic [31:0] v;
    rd(5'd0, v);
    cycle(1'b0, 1'b1, 5'd0, v);
    chk_reg("R5 first cleared by write-back", 5'd0, 32'h0);
    chk("R5 err_any low after clear", {31'h0, err_any}, 32'h0);
    rd(5'd1, v);
    cycle(1'b0, 1'b1, 5'd1, v);
    chk_reg("R5 next cleared by write-back", 5'd1, 32'h0);
    cycle(1'b0, 1'b1, 5'd11, 32'h0);
    chk_reg("R5 log write ignored", 5'd11, 32'h0007_53A5);
    cycle(1'b0, 1'b1, 5'd8, 32'h2);
    chk_reg("R5 partial valid clear", 5'd8, 32'h4);
    cycle(1'b0, 1'b1, 5'd8, 32'h4);
    chk_reg("R5 ch0 valid cleared", 5'd8, 32'h0);
    cycle(1'b0, 1'b1, 5'd16, 32'h1);
    chk_reg("R5 ch1 valid cleared", 5'd16, 32'h0);
  endtask

  task automatic t_refill;
    load_evt(5'd16, 1'b0, 3'd7, 3'd6, 8'h5A, 13'h0FFF, 16'h1234, 32'hCAFE_F00D, 18'h3FFFF);
    cycle(1'b1, 1'b0, 5'd0, 32'h0);
    chk_reg("R8 ch0 rec refilled after clear", 5'd11, 32'h0008_765A);
    chk_reg("R8 ch0 locator refilled", 5'd14, 32'h0003_FFFF);
    chk_reg("R2 first type 16 ch0", 5'd0, 32'h0001_0000);
    cycle(1'b0, 1'b1, 5'd0, 32'h0001_0000);
    cycle(1'b0, 1'b1, 5'd8, 32'h6);
    chk_reg("R5 ch0 valid cleared again", 5'd8, 32'h0);
  endtask

  task automatic t_spd;
    simple(5'd18, 1'b1);
    chk_reg("R1 type 18 flag with ch1", 5'd0, 32'h1004_0000);
    chk("R4 err_any ignores bit 18", {31'h0, err_any}, 32'h0);
    chk_reg("R7 type 18 fills no log", 5'd16, 32'h0);
    cycle(1'b0, 1'b1, 5'd0, 32'h1004_0000);
    chk_reg("R5 first cleared after spd", 5'd0, 32'h0);
  endtask

  task automatic t_unimpl;
    simple(5'd2, 1'b0);
    simple(5'd31, 1'b1);
    simple(5'd13, 1'b0);
    chk_reg("R1 unimplemented types: first", 5'd0, 32'h0);
    chk_reg("R1 unimplemented types: next", 5'd1, 32'h0);
    chk_reg("R1 unimplemented types: ch0 valid", 5'd8, 32'h0);
    chk_reg("R1 unimplemented types: ch1 valid", 5'd16, 32'h0);
  endtask

  task automatic t_type1;
    simple(5'd1, 1'b0);
    chk_reg("R1 type 1 sets bit 0", 5'd0, 32'h0000_0001);
    chk_reg("R7 type 1 nrec valid", 5'd8, 32'h1);
    chk_reg("R7 type 1 nrec word A", 5'd9, 32'h0000_8000);
    cycle(1'b0, 1'b1, 5'd0, 32'h1);
    cycle(1'b0, 1'b1, 5'd8, 32'h1);
    chk_reg("R5 type 1 state cleared", 5'd8, 32'h0);
  endtask

  task automatic t_same_cycle;
    simple(5'd4, 1'b0);
    chk_reg("R7 type 4 nrec word A", 5'd9, 32'h0002_0000);
    simple(5'd5, 1'b0);
    chk_reg("R8 nrec locked against type 5", 5'd9, 32'h0002_0000);
    chk_reg("R3 next holds type 5", 5'd1, 32'h0000_0020);
    load_evt(5'd5, 1'b0, 3'd0, 3'd0, 8'h00, 13'h0, 16'h0, 32'h0, 18'h0);
    cycle(1'b1, 1'b1, 5'd1, 32'h0000_0020);
    chk_reg("R9 next bit survives coincident clear", 5'd1, 32'h0000_0020);
    load_evt(5'd6, 1'b0, 3'd0, 3'd0, 8'h00, 13'h0, 16'h0, 32'h0, 18'h0);
    cycle(1'b1, 1'b1, 5'd8, 32'h1);
    chk_reg("R9 valid survives coincident clear", 5'd8, 32'h1);
    chk_reg("R9 nrec refilled by coincident event", 5'd9, 32'h0003_0000);
    chk_reg("R3 next accumulates type 6", 5'd1, 32'h0000_0060);
    cycle(1'b0, 1'b1, 5'd0, 32'h10);
    cycle(1'b0, 1'b1, 5'd1, 32'h60);
    cycle(1'b0, 1'b1, 5'd8, 32'h1);
    chk_reg("R5 all clear at end", 5'd0, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    evt_valid = 1'b0;
    sw_wr = 1'b0;
    sw_addr = '0;
    sw_wdata = '0;
    load_evt(5'd0, 1'b0, 3'd0, 3'd0, 8'h00, 13'h0, 16'h0, 32'h0, 18'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_first_capture;
    t_next;
    t_lock;
    t_clear;
    t_refill;
    t_spd;
    t_unimpl;
    t_type1;
    t_same_cycle;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule